// File: doc/BRIEF.md
# Power Signal Sequencing Checker

This block is a passive monitor for the power-control and reset lines of a low-power processor interface. It samples stop-clock, sleep, deep-sleep, deep-stop, the processor reset, a snoop request strobe and a generic bus-event strobe on every bus clock. From these it tracks which power state the interface is in: run, stop-grant, sleep, or the wake window that follows sleep. When the inputs break an ordering or timing rule, it raises a sticky flag. The block never drives any of the lines it watches.

Intervals are measured in two ways. Short intervals are counted directly in bus clocks. The long setup interval before reset release is counted in timebase ticks. A tick is made by dividing the bus clock by `TICK_DIV`, so `TICK_DIV * SETUP_TICKS` bus clocks stand for the required setup time.

Each rule has its own flag bit. Software clears a flag by writing one to the matching bit of `clr_flags`. `fault_code` gives the code of the most recent violation.

Top module: `pwr_seq_checker`

## Requirements
- R1: When `sys_rst` is sampled low after being high, flag bit 0 (code 1) is set if any of the four power lines is asserted in that cycle. It is also set if the four lines have not all been low for at least `(SETUP_TICKS+1)*TICK_DIV` consecutive bus clocks before that cycle. Any re-assertion of a power line restarts the interval.
- R2: After sleep is sampled low in the sleep state, stop-clock must remain high for at least `WAKE_GAP` bus clocks. If stop-clock is sampled low fewer than `WAKE_GAP` clocks after the clock that saw sleep low, flag bit 1 (code 2) is set. Stop-clock low in that same clock counts as a gap of zero.
- R3: If sleep rises while the tracked state is not stop-grant (that is, in run or in the wake window), flag bit 2 (code 3) is set. A rise in stop-grant is legal.
- R4: While in the sleep state with sleep still high, a bus-event strobe, a change of stop-clock or a change of deep-stop sets flag bit 3 (code 4). Changes of deep-sleep are ignored.
- R5: A snoop request sets flag bit 4 (code 5) in any of these cases: in the sleep state, in the wake window, or in the clock where sleep rises. A snoop in stop-grant or run is ignored.
- R6: Suppose `sys_rst` rises while in the sleep state. If sleep or stop-clock is still high `GRACE` clocks after the clock that sampled the reset rise, flag bit 5 (code 6) is set.
- R7: Flags are sticky. Writing one to a bit of `clr_flags` clears that bit one clock later, and other bits are unaffected. A new violation in the same clock wins over the clear. Every flag is visible the clock after the edge that sampled the offending input.
- R8: `fault_code` takes the code (flag bit index plus one) of the lowest-numbered flag raised in the most recent violating clock. It holds that value until the next violation, and returns to 0 when a clear leaves no flag set.
- R9: While `sys_rst` is high, rules R3, R4 and R5 are not checked. After `rst_n` the flags and the code are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset of the checker itself |
| sys_rst | input | 1 | Monitored processor reset, high = asserted |
| stop_req | input | 1 | Monitored stop-clock line, high = asserted |
| slp_req | input | 1 | Monitored sleep line, high = asserted |
| dslp_req | input | 1 | Monitored deep-sleep line, high = asserted |
| dstop_req | input | 1 | Monitored deep-stop line, high = asserted |
| snoop_req | input | 1 | Snoop request seen on the bus, one per clock |
| bus_evt | input | 1 | Any other bus transaction or signal activity |
| clr_flags | input | 6 | Write-one-to-clear per flag bit |
| fault_flags | output | 6 | Sticky violation flags, bit n = code n+1 |
| fault_code | output | 3 | Code of the latest violation, 0 = none |

## Verification
The embedded assertions watch, on every clock, the event-to-flag links for reset release with a line still asserted, a short wake gap, a sleep rise outside stop-grant, activity and snoops in sleep, flag stickiness, and the agreement between the code and the flags. Some behaviour can only be shown by the bench's sweeps: the exact boundary of the tick-counted setup interval, the restart of that interval, the wake gap and grace boundaries, priority between simultaneous violations, and inputs that must be ignored. These sweeps step each interval one clock at a time across its threshold and compare against limits computed from the parameters.

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int TICK_DIV    = 100,
  parameter int SETUP_TICKS = 450,
  parameter int WAKE_GAP    = 10,
  parameter int GRACE       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       stop_req,
  input  logic       slp_req,
  input  logic       dslp_req,
  input  logic       dstop_req,
  input  logic       snoop_req,
  input  logic       bus_evt,
  input  logic [5:0] clr_flags,
  output logic [5:0] fault_flags,
  output logic [2:0] fault_code
);

  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW = $clog2(SETUP_TICKS + 2);
  localparam int WW = $clog2(WAKE_GAP + 1);
  localparam int GW = $clog2(GRACE + 1);

  typedef enum logic [1:0] {ST_RUN, ST_GRANT, ST_SLEEP, ST_WAKE} pstate_t;

  pstate_t        st, nxt;
  logic           rst_q, stop_q, slp_q, dstop_q;
  logic [DW-1:0]  div;
  logic [SW-1:0]  scnt;
  logic [WW-1:0]  wcnt;
  logic [GW-1:0]  gcnt;
  logic           armed;
  logic [5:0]     hit;
  logic [2:0]     hit_code;

  wire quiet    = ~(stop_req | slp_req | dslp_req | dstop_req);
  wire tick     = (div == DW'(TICK_DIV - 1));
  wire slp_rise = slp_req & ~slp_q;
  wire rst_fall = ~sys_rst & rst_q;
  wire rst_rise = sys_rst & ~rst_q;
  wire held     = slp_req | stop_req;
  wire wake_ok  = (wcnt >= WW'(WAKE_GAP - 1));

  always_comb begin
    hit = '0;
    nxt = st;
    if (sys_rst) begin
      nxt = stop_req ? ST_GRANT : ST_RUN;
    end else begin
      case (st)
        ST_RUN:
          if (slp_rise) begin
            hit[2] = 1'b1;
            nxt    = ST_SLEEP;
          end else if (stop_req) nxt = ST_GRANT;
        ST_GRANT:
          if (slp_rise) nxt = ST_SLEEP;
          else if (!stop_req) nxt = ST_RUN;
        ST_SLEEP:
          if (!slp_req) begin
            if (!stop_req) begin
              hit[1] = 1'b1;
              nxt    = ST_RUN;
            end else nxt = ST_WAKE;
          end else if (bus_evt || (stop_req != stop_q) || (dstop_req != dstop_q)) begin
            hit[3] = 1'b1;
          end
        ST_WAKE:
          if (slp_rise) begin
            hit[2] = 1'b1;
            nxt    = ST_SLEEP;
          end else if (!stop_req) begin
            hit[1] = !wake_ok;
            nxt    = ST_RUN;
          end else if (wake_ok) nxt = ST_GRANT;
        default: nxt = ST_RUN;
      endcase
      if (snoop_req && (st == ST_SLEEP || st == ST_WAKE || slp_rise)) hit[4] = 1'b1;
    end
    if (rst_fall && (!quiet || scnt < SW'(SETUP_TICKS + 1))) hit[0] = 1'b1;
    if (armed && held && gcnt == GW'(GRACE - 1)) hit[5] = 1'b1;
  end

  always_comb begin
    hit_code = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (hit[i]) hit_code = 3'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      rst_q   <= 1'b0;
      stop_q  <= 1'b0;
      slp_q   <= 1'b0;
      dstop_q <= 1'b0;
    end else begin
      st      <= nxt;
      rst_q   <= sys_rst;
      stop_q  <= stop_req;
      slp_q   <= slp_req;
      dstop_q <= dstop_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      scnt <= '0;
    end else if (!quiet) begin
      div  <= '0;
      scnt <= '0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick && scnt != SW'(SETUP_TICKS + 1)) scnt <= scnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (st != ST_WAKE) wcnt <= '0;
    else if (!wake_ok) wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gcnt  <= '0;
    end else if (rst_rise && st == ST_SLEEP) begin
      armed <= 1'b1;
      gcnt  <= '0;
    end else if (armed) begin
      if (!held || gcnt == GW'(GRACE - 1)) armed <= 1'b0;
      else gcnt <= gcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_flags <= '0;
      fault_code  <= '0;
    end else begin
      fault_flags <= (fault_flags & ~clr_flags) | hit;
      if (hit != '0) fault_code <= hit_code;
      else if ((fault_flags & ~clr_flags) == '0) fault_code <= '0;
    end
  end

  // R1
  setup_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) && (stop_req || slp_req || dslp_req || dstop_req) |=> fault_flags[0]);

  // R2
  wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst && st == ST_WAKE && !slp_req && $fell(stop_req) && !wake_ok |=> fault_flags[1]);

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst && $rose(slp_req) && st != ST_GRANT |=> fault_flags[2]);

  // R4
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst && st == ST_SLEEP && slp_req && bus_evt |=> fault_flags[3]);

  // R5
  sleep_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst && st == ST_SLEEP && snoop_req |=> fault_flags[4]);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fault_flags & $past(fault_flags & ~clr_flags)) == $past(fault_flags & ~clr_flags)));

  // R8
  code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flags != '0) |-> (fault_code != 3'd0 && fault_code <= 3'd6));

endmodule

// File: tb/test_pwr_seq_checker.sv
`timescale 1ns/1ps
module test_pwr_seq_checker;
  localparam int TD = 2, ST = 3, WG = 10, GR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_rst = 1'b0, stop_req = 1'b0, slp_req = 1'b0, dslp_req = 1'b0, dstop_req = 1'b0;
  logic snoop_req = 1'b0, bus_evt = 1'b0;
  logic [5:0] clr_flags = '0;
  logic [5:0] fault_flags;
  logic [2:0] fault_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_checker #(.TICK_DIV(TD), .SETUP_TICKS(ST), .WAKE_GAP(WG), .GRACE(GR)) i_pwr_seq_checker (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .stop_req(stop_req), .slp_req(slp_req),
    .dslp_req(dslp_req), .dstop_req(dstop_req), .snoop_req(snoop_req), .bus_evt(bus_evt),
    .clr_flags(clr_flags), .fault_flags(fault_flags), .fault_code(fault_code));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_flags = '1; cyc(1); clr_flags = '0;
  endtask

  task automatic enter_sleep();
    stop_req = 1'b1; cyc(2); slp_req = 1'b1; cyc(2);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    check("R9 reset flags", fault_flags, 0);
    check("R9 reset code", fault_code, 0);

    // R1: setup interval sweep across the boundary
    for (int n = 1; n <= 12; n++) begin
      sys_rst = 1'b1; stop_req = 1'b1; cyc(3);
      stop_req = 1'b0; cyc(n);
      sys_rst = 1'b0; cyc(1);
      check("R1 setup sweep", fault_flags, ((n / TD) > ST) ? 0 : 1);
      clear_all(); cyc(1);
    end
    sys_rst = 1'b1; cyc(2); dslp_req = 1'b1; cyc(1); dslp_req = 1'b0; cyc(6);
    dslp_req = 1'b1; cyc(1); dslp_req = 1'b0; cyc(7); sys_rst = 1'b0; cyc(1);
    check("R1 restart interval", fault_flags, 1);
    clear_all();
    sys_rst = 1'b1; cyc(2); dstop_req = 1'b1; cyc(10); sys_rst = 1'b0; cyc(1);
    check("R1 line held", fault_flags, 1);
    check("R8 code setup", fault_code, 1);
    dstop_req = 1'b0; clear_all(); cyc(1);
    check("R8 code cleared", fault_code, 0);

    // R2: wake gap sweep
    for (int g = 0; g <= 13; g++) begin
      enter_sleep(); cyc(1);
      slp_req = 1'b0;
      if (g == 0) stop_req = 1'b0;
      else begin cyc(g); stop_req = 1'b0; end
      cyc(1);
      check("R2 wake gap flags", fault_flags, (g < WG) ? 2 : 0);
      check("R2 wake gap code", fault_code, (g < WG) ? 2 : 0);
      clear_all(); cyc(1);
    end

    // R3: sleep rise outside stop-grant
    slp_req = 1'b1; cyc(1);
    check("R3 sleep from run", fault_flags[2], 1);
    check("R3 code", fault_code, 3);
    slp_req = 1'b0; cyc(1); clear_all();
    enter_sleep(); slp_req = 1'b0; cyc(3); slp_req = 1'b1; cyc(1);
    check("R3 sleep in wake window", fault_flags[2], 1);
    slp_req = 1'b0; stop_req = 1'b0; cyc(1); clear_all(); cyc(1);
    enter_sleep();
    check("R3 sleep from grant legal", fault_flags, 0);

    // R4, R5, R7 in sleep
    dslp_req = 1'b1; cyc(1); dslp_req = 1'b0; cyc(1);
    check("R4 deep-sleep ignored", fault_flags, 0);
    bus_evt = 1'b1; cyc(1); bus_evt = 1'b0;
    check("R4 bus event in sleep", fault_flags, 6'b001000);
    check("R8 code bus event", fault_code, 4);
    snoop_req = 1'b1; cyc(1); snoop_req = 1'b0;
    check("R5 snoop in sleep", fault_flags, 6'b011000);
    check("R8 latest code", fault_code, 5);
    clr_flags = 6'b001000; cyc(1); clr_flags = '0;
    check("R7 partial clear", fault_flags, 6'b010000);
    check("R8 code held", fault_code, 5);
    clear_all();
    bus_evt = 1'b1; clr_flags = '1; cyc(1); bus_evt = 1'b0; clr_flags = '0;
    check("R7 set wins over clear", fault_flags, 6'b001000);
    clear_all();
    stop_req = 1'b0; cyc(1); stop_req = 1'b1;
    check("R4 stop-clock change in sleep", fault_flags, 6'b001000);
    cyc(1); clear_all();
    slp_req = 1'b0; cyc(2); snoop_req = 1'b1; cyc(1); snoop_req = 1'b0;
    check("R5 snoop in wake window", fault_flags, 6'b010000);
    cyc(WG); stop_req = 1'b0; cyc(1); clear_all(); cyc(1);
    stop_req = 1'b1; cyc(2); snoop_req = 1'b1; cyc(1); snoop_req = 1'b0;
    check("R5 snoop in grant ignored", fault_flags, 0);
    slp_req = 1'b1; snoop_req = 1'b1; cyc(1); snoop_req = 1'b0;
    check("R5 snoop on sleep entry", fault_flags, 6'b010000);
    slp_req = 1'b0; cyc(WG + 1); stop_req = 1'b0; cyc(1); clear_all(); cyc(1);

    // R8 priority of simultaneous violations
    slp_req = 1'b1; snoop_req = 1'b1; cyc(1); snoop_req = 1'b0;
    check("R8 two flags", fault_flags, 6'b010100);
    check("R8 lowest code wins", fault_code, 3);
    slp_req = 1'b0; cyc(1); clear_all(); cyc(1);

    // R6: grace sweep
    for (int j = 1; j <= 6; j++) begin
      enter_sleep();
      sys_rst = 1'b1; cyc(j);
      slp_req = 1'b0; stop_req = 1'b0; cyc(2);
      check("R6 grace sweep", fault_flags, (j > GR) ? 6'b100000 : 0);
      cyc(12); sys_rst = 1'b0; cyc(1);
      check("R6 clean release", fault_flags[0], 0);
      clear_all(); cyc(1);
    end

    // R9: checks suppressed while reset held
    sys_rst = 1'b1; stop_req = 1'b1; cyc(2);
    slp_req = 1'b1; snoop_req = 1'b1; bus_evt = 1'b1; cyc(1);
    snoop_req = 1'b0; bus_evt = 1'b0; cyc(1);
    check("R9 rules off in reset", fault_flags, 0);
    slp_req = 1'b0; stop_req = 1'b0; cyc(12); sys_rst = 1'b0; cyc(2);
    check("R9 clean exit", fault_flags, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule